// File: doc/BRIEF.md
# Byte-Lane Synchronous SRAM Datapath

This block is the storage array and data path of a synchronous static memory organised as byte lanes. On every rising clock edge it captures the address, the write data and the write controls. A write is then committed to the array by the block itself, with no further control from the requester. A write can cover any subset of the byte lanes, selected by per-lane enables qualified by a byte-write enable. A separate global write enable stores the whole word whatever the lane enables say.

A static mode input chooses between flow-through reads, which take one clock after capture, and pipelined reads, which take two. A write is held for one cycle in a commit stage before it reaches the array. A read that arrives in that cycle takes the written lanes from the commit stage and the other lanes from the array. An asynchronous active-low output enable and an asynchronous power-down input both force the data outputs to high impedance. Power-down also freezes all internal state, so neither the array nor any in-flight operation changes. The full-size part uses `ADDR_W = 15` (32768 words of 32 bits). The default is smaller to keep the elaborated array modest.

Top module: `bwsram_dp`

## Requirements
- R1: After reset, `dq_en_o` is low until a read has been captured and has reached the output.
- R2: An edge with `sel_i` high and `gw_ni` low writes all four byte lanes of `dq_i` to `addr_i`, whatever the values of `be_ni` and `bwe_ni`.
- R3: An edge with `sel_i` high, `gw_ni` high and `bwe_ni` low writes lane `l` (bits `8l+7:8l`) only where `be_ni[l]` is low. If every `be_ni` bit is high, no lane is written.
- R4: An edge with `sel_i` high and both `gw_ni` and `bwe_ni` high is a read: the array is not modified, whatever `be_ni` and `dq_i` carry.
- R5: With `pipe_i` low, a read captured at edge k drives `dq_en_o` high and `dq_o` with the word after edge k+1, and not earlier.
- R6: With `pipe_i` high, a read captured at edge k drives the word after edge k+2, provided that the cycle after it is also selected. Nothing is driven after edge k+1.
- R7: A read captured on the edge right after a write to the same address returns the newly written word, in both modes. A read captured after two back-to-back writes returns the first write's data for its address.
- R8: After a partial write, a read that immediately follows it returns the written lanes from the new data and the unwritten lanes from the earlier contents.
- R9: While `oe_ni` is high, `dq_en_o` is low at once, without waiting for a clock edge. It returns high as soon as `oe_ni` falls again.
- R10: When a deselect (`sel_i` low) is captured at edge k, `dq_en_o` is low after edge k+1 in both modes. This holds even when a pipelined read captured at edge k-1 would otherwise have been driven then.
- R11: While `zz_i` is high, `dq_en_o` is low, no input is captured and no internal state changes. A write still waiting in the commit stage completes after `zz_i` falls, and a captured read delivers its data after `zz_i` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Chip-select status from the sequencer; low is a deselect cycle |
| addr_i | input | ADDR_W | Word address, captured on the edge |
| dq_i | input | DATA_W | Write data, captured on the edge |
| gw_ni | input | 1 | Global write enable, active low |
| bwe_ni | input | 1 | Byte-write enable, active low |
| be_ni | input | DATA_W/8 | Per-lane write enables, active low |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| pipe_i | input | 1 | Read mode: 1 selects pipelined, 0 selects flow-through |
| zz_i | input | 1 | Asynchronous power-down, active high |
| dq_o | output | DATA_W | Read data, zero while not driven |
| dq_en_o | output | 1 | Output driver enable; low means the data pins are high impedance |

## Verification
The hardest case to reach is a read that lands on a word whose partial write is still in the commit stage. There the result mixes lanes from two sources. The bench reaches it by issuing every one of the sixteen lane masks as a write followed at once by a read of the same address, in both read modes. The other hard case is a pipelined read cut off by a deselect in the very next cycle. Power-down is raised in the one cycle when a write has been captured but not yet committed, and again in the cycle when a read has been captured but not yet loaded. This shows that both operations resume cleanly.

// File: rtl/bwsram_pkg.sv
`timescale 1ns/1ps
package bwsram_pkg;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/bwsram_req.sv
`timescale 1ns/1ps
// Input capture stage: address, data, lane mask and operation type.
module bwsram_req
  import bwsram_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int LANES  = 4,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     data_i,
  input  logic              gw_ni,
  input  logic              bwe_ni,
  input  logic [LANES-1:0]  be_ni,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DW-1:0]     data_o,
  output logic [LANES-1:0]  mask_o
);
  logic             wr_d;
  logic [LANES-1:0] mask_d;
  op_e              op_d;

  always_comb begin
    wr_d = !gw_ni || !bwe_ni;
    if (!gw_ni)       mask_d = '1;
    else if (!bwe_ni) mask_d = ~be_ni;
    else              mask_d = '0;
    if (!sel_i)     op_d = OP_IDLE;
    else if (wr_d)  op_d = OP_WRITE;
    else            op_d = OP_READ;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_o   <= OP_IDLE;
      addr_o <= '0;
      data_o <= '0;
      mask_o <= '0;
    end else if (!hold_i) begin
      op_o   <= op_d;
      addr_o <= addr_i;
      data_o <= data_i;
      mask_o <= mask_d;
    end
  end

  assert_gw_all_lanes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && sel_i && !gw_ni) |=> (op_o == OP_WRITE && mask_o == {LANES{1'b1}}));

  assert_read_no_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && sel_i && gw_ni && bwe_ni) |=> (op_o == OP_READ && mask_o == '0));
endmodule

// File: rtl/bwsram_array.sv
`timescale 1ns/1ps
// Per-lane storage with a one-entry commit stage and lane-wise bypass.
module bwsram_array
  import bwsram_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int LANES  = 4,
  localparam int DW    = LANES * LANE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     data_i,
  input  logic [LANES-1:0]  mask_i,
  output logic [DW-1:0]     rd_word_o
);
  logic              pend_vld_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DW-1:0]     pend_data_q;
  logic [LANES-1:0]  pend_mask_q;
  logic              hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vld_q  <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
      pend_mask_q <= '0;
    end else if (!hold_i) begin
      pend_vld_q  <= (op_i == OP_WRITE);
      pend_addr_q <= addr_i;
      pend_data_q <= data_i;
      pend_mask_q <= mask_i;
    end
  end

  assign hit = pend_vld_q && (pend_addr_q == addr_i);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (!hold_i && pend_vld_q && pend_mask_q[l])
        mem_q[pend_addr_q] <= pend_data_q[l*LANE_W +: LANE_W];
    end

    // a read may land while the write is still pending: take written lanes from it
    assign rd_word_o[l*LANE_W +: LANE_W] = (hit && pend_mask_q[l])
                                         ? pend_data_q[l*LANE_W +: LANE_W]
                                         : mem_q[addr_i];
  end

  assert_zz_freezes_commit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> ($stable(pend_vld_q) && $stable(pend_addr_q) && $stable(pend_mask_q)));
endmodule

// File: rtl/bwsram_rdpipe.sv
`timescale 1ns/1ps
// Read stages: stage 1 feeds flow-through, stage 2 feeds pipelined mode.
module bwsram_rdpipe
  import bwsram_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  logic          pipe_i,
  input  logic          oe_ni,
  input  op_e           op_i,
  input  logic [DW-1:0] rd_word_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_en_o
);
  logic          s1_vld_q, s2_vld_q;
  logic [DW-1:0] s1_data_q, s2_data_q;
  logic          vld_sel;
  logic [DW-1:0] data_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q  <= 1'b0;
      s2_vld_q  <= 1'b0;
      s1_data_q <= '0;
      s2_data_q <= '0;
    end else if (!hold_i) begin
      s1_vld_q  <= (op_i == OP_READ);
      s1_data_q <= rd_word_i;
      // a captured deselect cancels the stage-2 word one cycle later
      s2_vld_q  <= s1_vld_q && (op_i != OP_IDLE);
      s2_data_q <= s1_data_q;
    end
  end

  always_comb begin
    vld_sel  = pipe_i ? s2_vld_q  : s1_vld_q;
    data_sel = pipe_i ? s2_data_q : s1_data_q;
    dq_en_o  = vld_sel && !oe_ni && !hold_i;
    dq_o     = dq_en_o ? data_sel : '0;
  end

  assert_flow_latency_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !pipe_i && op_i == OP_READ) |=> (hold_i || oe_ni || pipe_i || dq_en_o));

  assert_deselect_one_cycle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && op_i == OP_IDLE) |=> !dq_en_o);
endmodule

// File: rtl/bwsram_dp.sv
`timescale 1ns/1ps
module bwsram_dp
  import bwsram_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_i,
  input  logic              gw_ni,
  input  logic              bwe_ni,
  input  logic [LANES-1:0]  be_ni,
  input  logic              oe_ni,
  input  logic              pipe_i,
  input  logic              zz_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_en_o
);
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [LANES-1:0]  mask_q;
  logic [DATA_W-1:0] rd_word;

  bwsram_req #(.ADDR_W(ADDR_W), .LANES(LANES)) u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (zz_i),
    .sel_i  (sel_i),
    .addr_i (addr_i),
    .data_i (dq_i),
    .gw_ni  (gw_ni),
    .bwe_ni (bwe_ni),
    .be_ni  (be_ni),
    .op_o   (op_q),
    .addr_o (addr_q),
    .data_o (data_q),
    .mask_o (mask_q)
  );

  bwsram_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_i    (zz_i),
    .op_i      (op_q),
    .addr_i    (addr_q),
    .data_i    (data_q),
    .mask_i    (mask_q),
    .rd_word_o (rd_word)
  );

  bwsram_rdpipe #(.DW(DATA_W)) u_rdpipe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_i    (zz_i),
    .pipe_i    (pipe_i),
    .oe_ni     (oe_ni),
    .op_i      (op_q),
    .rd_word_i (rd_word),
    .dq_o      (dq_o),
    .dq_en_o   (dq_en_o)
  );

  assert_oe_zz_hiz_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_ni || zz_i) |-> !dq_en_o);
endmodule

// File: tb/bwsram_dp_test.sv
`timescale 1ns/1ps
module bwsram_dp_test;
  localparam int AW    = 4;
  localparam int N     = 1 << AW;
  localparam real CLK_P = 8.0;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sel_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0]   dq_i = '0;
  logic          gw_ni = 1'b1, bwe_ni = 1'b1;
  logic [3:0]    be_ni = 4'hF;
  logic          oe_ni = 1'b0, pipe_i = 1'b0, zz_i = 1'b0;
  logic [31:0]   dq_o;
  logic          dq_en_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] mdl [N];

  bwsram_dp #(.ADDR_W(AW), .DATA_W(32)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .addr_i(addr_i), .dq_i(dq_i),
    .gw_ni(gw_ni), .bwe_ni(bwe_ni), .be_ni(be_ni), .oe_ni(oe_ni), .pipe_i(pipe_i),
    .zz_i(zz_i), .dq_o(dq_o), .dq_en_o(dq_en_o)
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic s, input int a, input logic [31:0] d,
                       input logic gw, input logic bwe, input logic [3:0] be);
    sel_i = s; addr_i = a[AW-1:0]; dq_i = d; gw_ni = gw; bwe_ni = bwe; be_ni = be;
    @(negedge clk_i);
  endtask

  task automatic idle();
    drive(1'b0, 0, 32'h0, 1'b1, 1'b1, 4'hF);
  endtask

  task automatic rd(input int a);
    drive(1'b1, a, 32'h0, 1'b1, 1'b1, 4'hF);
  endtask

  task automatic wr(input int a, input logic [31:0] d, input logic gw,
                    input logic bwe, input logic [3:0] be);
    drive(1'b1, a, d, gw, bwe, be);
    for (int l = 0; l < 4; l++)
      if (!gw || (!bwe && !be[l])) mdl[a][l*8 +: 8] = d[l*8 +: 8];
  endtask

  task automatic read_check(input int a, input string tag);
    rd(a);
    if (pipe_i) rd(a);
    idle();
    chk({tag, " enable"}, {31'b0, dq_en_o}, 32'd1);
    chk(tag, dq_o, mdl[a]);
    idle(); idle();
  endtask

  task automatic stream_check(input string tag);
    int lat;
    lat = pipe_i ? 2 : 1;
    for (int i = 0; i < N + lat; i++) begin
      if (i < N) rd(i);
      else if (i < N + lat - 1) rd(0);
      else idle();
      if (i >= lat) begin
        chk({tag, " enable"}, {31'b0, dq_en_o}, 32'd1);
        chk(tag, dq_o, mdl[i-lat]);
      end
    end
    idle(); idle();
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 reset output disabled", {31'b0, dq_en_o}, 32'd0);

    // R2: global write overrides any lane enables
    for (int a = 0; a < N; a++)
      wr(a, (32'(a) * 32'h1111_1111) ^ 32'hA5C3_0F96, 1'b0, a[0], 4'(a));
    stream_check("R2 global write flow sweep");

    // R3: all sixteen lane masks, read back pipelined
    pipe_i = 1'b1; idle();
    for (int a = 0; a < N; a++)
      wr(a, ~mdl[a] + 32'(a), 1'b1, 1'b0, ~4'(a));
    stream_check("R3 byte write pipe sweep");

    // R4: read cycles with data and lane enables active must not write
    pipe_i = 1'b0; idle();
    for (int a = 0; a < N; a++)
      drive(1'b1, a, ~mdl[a], 1'b1, 1'b1, 4'h0);
    idle(); idle();
    stream_check("R4 no write on read");

    // R5 exact flow latency, R10 deselect after it
    idle();
    rd(7);
    chk("R5 not driven at k", {31'b0, dq_en_o}, 32'd0);
    idle();
    chk("R5 driven after k+1", {31'b0, dq_en_o}, 32'd1);
    chk("R5 data after k+1", dq_o, mdl[7]);
    idle();
    chk("R10 flow deselect", {31'b0, dq_en_o}, 32'd0);

    // R6 exact pipelined latency
    pipe_i = 1'b1; idle(); idle();
    rd(7);
    chk("R6 not driven at k", {31'b0, dq_en_o}, 32'd0);
    rd(7);
    chk("R6 not driven after k+1", {31'b0, dq_en_o}, 32'd1 & 32'd0);
    idle();
    chk("R6 driven after k+2", {31'b0, dq_en_o}, 32'd1);
    chk("R6 data after k+2", dq_o, mdl[7]);
    idle();
    chk("R10 pipe deselect", {31'b0, dq_en_o}, 32'd0);

    // R10: pipelined read cancelled by an immediate deselect
    idle();
    rd(9);
    idle();
    chk("R10 pipe cut k+1", {31'b0, dq_en_o}, 32'd0);
    idle();
    chk("R10 pipe cut k+2", {31'b0, dq_en_o}, 32'd0);
    idle();

    // R7/R8 pass-through in both modes
    for (int m = 0; m < 2; m++) begin
      pipe_i = m[0]; idle(); idle();
      for (int a = 0; a < N; a++) begin
        wr(a, {4{8'(a * 16 + m + 3)}}, 1'b1, 1'b0, 4'(a));
        read_check(a, "R8 partial pass-through");
      end
      for (int a = 0; a < N; a += 5) begin
        wr(a, 32'hC0DE_0000 | 32'(a * 7 + m), 1'b0, 1'b1, 4'hF);
        read_check(a, "R7 full pass-through");
      end
      wr(2, 32'h2222_0000 + 32'(m), 1'b0, 1'b1, 4'hF);
      wr(3, 32'h3333_0000 + 32'(m), 1'b0, 1'b1, 4'hF);
      read_check(2, "R7 back-to-back writes");
      read_check(3, "R7 second of back-to-back writes");
    end

    // R9: asynchronous output enable
    pipe_i = 1'b0; idle(); idle();
    rd(4);
    idle();
    chk("R9 driven with oe low", {31'b0, dq_en_o}, 32'd1);
    oe_ni = 1'b1; #1;
    chk("R9 oe high disables at once", {31'b0, dq_en_o}, 32'd0);
    oe_ni = 1'b0; #1;
    chk("R9 oe low re-enables", {31'b0, dq_en_o}, 32'd1);
    chk("R9 data kept", dq_o, mdl[4]);
    idle(); idle();

    // R11: power-down with a write waiting in the commit stage
    wr(5, 32'hDEAD_BEEF, 1'b0, 1'b1, 4'hF);
    zz_i = 1'b1; #1;
    chk("R11 power-down disables output", {31'b0, dq_en_o}, 32'd0);
    for (int i = 0; i < 3; i++) begin
      drive(1'b1, 6, 32'h1234_5678, 1'b0, 1'b1, 4'h0);
      chk("R11 output low during power-down", {31'b0, dq_en_o}, 32'd0);
    end
    zz_i = 1'b0;
    idle(); idle();
    read_check(5, "R11 pending write survives power-down");
    read_check(6, "R11 write during power-down ignored");

    // R11: power-down with a captured read not yet loaded
    rd(3);
    zz_i = 1'b1;
    idle(); idle();
    chk("R11 frozen read not driven", {31'b0, dq_en_o}, 32'd0);
    zz_i = 1'b0; #1;
    chk("R11 read not loaded before edge", {31'b0, dq_en_o}, 32'd0);
    idle();
    chk("R11 read resumes enable", {31'b0, dq_en_o}, 32'd1);
    chk("R11 read resumes data", dq_o, mdl[3]);
    idle(); idle();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule